// File: doc/BRIEF.md
# Legacy voltage and tone switch controller

This block drives the committed switch lines of a satellite-dish slave controller while it is in legacy (non-framed) signalling mode. It watches two inputs sampled by the 8 MHz system clock. The first is a comparator bit that reports whether the bus DC level sits above the 15 V threshold. The second is the raw 22 kHz tone. From these it sets three output lines: polarisation (horizontal or vertical), band (high or low) and satellite position (A or B).

The tone is accepted only when its period, measured between rising edges, stays inside a window matching 17.6 to 26.4 kHz (303 to 454 clock cycles by default) for several periods in a row. Each stretch of accepted tone is a segment, timed from the moment it is accepted to the moment it is declared lost. A long segment is continuous tone. A single segment of burst length, followed by a quiet interval, is an unmodulated burst. Two or more short segments followed by a quiet interval form a modulated burst. A configuration bit routes continuous tone either to the band line or to the position line.

The block starts in legacy mode after reset. A pulse on `frame_seen` ends legacy mode, and from then on the switch lines are frozen for the command processor. A pulse on `reset_cmd` resumes legacy mode.

Top module: `lvt_top`

## Requirements
- R1: After reset, `legacy_mode` is 1 and `pol_horiz`, `band_high`, `pos_b` and `tone_det` are all 0.
- R2: In legacy mode, `pol_horiz` takes the value of `bus_v_high` (1 = above 15 V, read as 18 V, horizontal; 0 = vertical) once that input has held a new value for VQUAL consecutive cycles. A pulse shorter than VQUAL cycles leaves `pol_horiz` unchanged.
- R3: `tone_det` rises only after QUAL consecutive rising-edge-to-rising-edge periods each lie in [PER_MIN, PER_MAX] cycles. A tone that is too fast or too slow never sets it.
- R4: `tone_det` falls when no rising edge has been seen for GAP cycles.
- R5: With `cfg_tone_to_pos` = 0, a segment that lasts CONT_MIN cycles sets `band_high` to 1, and the loss of that tone clears it to 0. `pos_b` is not affected.
- R6: With `cfg_tone_to_pos` = 1, continuous tone drives `pos_b` in the same way, and `band_high` is not affected.
- R7: A single segment whose length lies in [BMIN, BMAX], followed by END_GAP quiet cycles, sets `pos_b` to 0 (position A).
- R8: Two or more segments, each shorter than BMIN, followed by END_GAP quiet cycles, set `pos_b` to 1 (position B).
- R9: A sequence that contains a segment longer than BMAX but shorter than CONT_MIN leaves `pos_b` unchanged.
- R10: A `frame_seen` pulse clears `legacy_mode`, and while it is 0 all three switch lines hold their values. `reset_cmd` sets `legacy_mode` again, and it wins when both pulses arrive in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 MHz system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_v_high | input | 1 | Comparator: bus DC level above 15 V |
| tone_raw | input | 1 | Unsynchronised 22 kHz tone input |
| cfg_tone_to_pos | input | 1 | 0: continuous tone drives the band line; 1: it drives the position line |
| frame_seen | input | 1 | Pulse: a valid framed command was received |
| reset_cmd | input | 1 | Pulse: return to legacy mode |
| legacy_mode | output | 1 | 1 while legacy signalling is in control |
| pol_horiz | output | 1 | 1 = horizontal, 0 = vertical |
| band_high | output | 1 | 1 = high band |
| pos_b | output | 1 | 1 = position B, 0 = position A |
| tone_det | output | 1 | Qualified tone present |

## Verification
The bench drives tones that are slightly too fast and too slow. A period check that was too loose would raise `tone_det` and the band line on these. It sends burst-length, short and in-between segments. A classifier that mixed up the length bands would set position B on a plain burst, or would move the position line on the in-between segment. It applies voltage glitches shorter than the qualification window; a design without the filter would flip polarisation. It also checks that continuous tone and voltage changes have no effect on the outputs after `frame_seen`, and that `reset_cmd` wins when both pulses arrive in the same cycle.

// File: rtl/lvt_pkg.sv
package lvt_pkg;
    typedef struct packed {
        logic cont_on;
        logic cont_off;
        logic pos_a;
        logic pos_b;
    } tone_evt_t;
endpackage

// File: rtl/lvt_sync.sv
module lvt_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] sh_q, sh_d;
        always_comb sh_d = {sh_q[STAGES-2:0], d[i]};
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= sh_d;
        end
        assign q[i] = sh_q[STAGES-1];
    end
endmodule

// File: rtl/lvt_tone_qual.sv
module lvt_tone_qual #(
    parameter int PER_MIN = 303,
    parameter int PER_MAX = 454,
    parameter int QUAL    = 4,
    parameter int GAP     = 1362
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tone_s,
    output logic present
);
    localparam int PW = $clog2(GAP + 1);
    localparam int GW = $clog2(QUAL + 1);
    localparam logic [PW-1:0] MIN_C = PW'(PER_MIN);
    localparam logic [PW-1:0] MAX_C = PW'(PER_MAX);
    localparam logic [PW-1:0] GAP_C = PW'(GAP);
    localparam logic [GW-1:0] QUAL_C = GW'(QUAL);

    typedef struct packed {
        logic          prev;
        logic [PW-1:0] per;
        logic [GW-1:0] good;
        logic          pres;
    } st_t;

    st_t s_q, s_d;
    logic rise;

    always_comb begin
        s_d = s_q;
        rise = tone_s & ~s_q.prev;
        s_d.prev = tone_s;
        if (rise) begin
            s_d.per = PW'(1);
            if (s_q.per >= MIN_C && s_q.per <= MAX_C) begin
                if (s_q.good != QUAL_C) s_d.good = s_q.good + 1'b1;
                if (s_d.good == QUAL_C) s_d.pres = 1'b1;
            end else begin
                s_d.good = '0;
            end
        end else if (s_q.per != GAP_C) begin
            s_d.per = s_q.per + 1'b1;
            if (s_d.per == GAP_C) begin
                s_d.pres = 1'b0;
                s_d.good = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{prev: 1'b0, per: GAP_C, good: '0, pres: 1'b0};
        else        s_q <= s_d;
    end

    assign present = s_q.pres;

    // R3: acceptance only follows a run of in-window periods
    a_r3_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.pres) |-> ($past(s_q.good) == QUAL_C - 1'b1));
    // R4: silence of GAP cycles drops the tone
    a_r4_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise && s_q.per == GAP_C - 1'b1) |=> !s_q.pres);
endmodule

// File: rtl/lvt_burst_class.sv
module lvt_burst_class
    import lvt_pkg::*;
#(
    parameter int BMIN     = 80000,
    parameter int BMAX     = 120000,
    parameter int CONT_MIN = 160000,
    parameter int END_GAP  = 40000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      present,
    output tone_evt_t evt
);
    localparam int SW = $clog2(CONT_MIN + 1);
    localparam int QW = $clog2(END_GAP + 1);
    localparam logic [SW-1:0] BMIN_C = SW'(BMIN);
    localparam logic [SW-1:0] BMAX_C = SW'(BMAX);
    localparam logic [SW-1:0] CONT_C = SW'(CONT_MIN);
    localparam logic [QW-1:0] END_C  = QW'(END_GAP);

    typedef struct packed {
        logic          pp;
        logic [SW-1:0] seg;
        logic          cont;
        logic [QW-1:0] quiet;
        logic          pend;
        logic          bseen;
        logic [1:0]    nshort;
    } st_t;

    st_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        evt = '0;
        s_d.pp = present;
        if (present) begin
            if (!s_q.pp)               s_d.seg = SW'(1);
            else if (s_q.seg != CONT_C) s_d.seg = s_q.seg + 1'b1;
            if (!s_q.cont && s_d.seg == CONT_C) begin
                s_d.cont   = 1'b1;
                evt.cont_on = 1'b1;
                s_d.pend   = 1'b0;
                s_d.bseen  = 1'b0;
                s_d.nshort = 2'd0;
                s_d.quiet  = '0;
            end
        end else if (s_q.pp) begin
            s_d.quiet = '0;
            if (s_q.cont) begin
                s_d.cont     = 1'b0;
                evt.cont_off = 1'b1;
            end else if (s_q.seg >= BMIN_C && s_q.seg <= BMAX_C) begin
                s_d.bseen = 1'b1;
                s_d.pend  = 1'b1;
            end else if (s_q.seg < BMIN_C) begin
                if (s_q.nshort != 2'd3) s_d.nshort = s_q.nshort + 1'b1;
                s_d.pend = 1'b1;
            end else begin
                s_d.bseen  = 1'b1;
                s_d.nshort = 2'd3;
                s_d.pend   = 1'b1;
            end
        end else if (s_q.pend) begin
            s_d.quiet = s_q.quiet + 1'b1;
            if (s_d.quiet == END_C) begin
                if (s_q.bseen && s_q.nshort == 2'd0)       evt.pos_a = 1'b1;
                else if (!s_q.bseen && s_q.nshort >= 2'd2) evt.pos_b = 1'b1;
                s_d.pend   = 1'b0;
                s_d.bseen  = 1'b0;
                s_d.nshort = 2'd0;
                s_d.quiet  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7 R8: at most one event per cycle
    a_r8_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt.cont_on, evt.cont_off, evt.pos_a, evt.pos_b}));
    // R5: continuous tone is declared only while the tone is present
    a_r5_cont_needs_tone: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.cont) |-> $past(present));
endmodule

// File: rtl/lvt_volt_filt.sv
module lvt_volt_filt #(
    parameter int VQUAL = 454
) (
    input  logic clk,
    input  logic rst_n,
    input  logic v_s,
    output logic pol
);
    localparam int CW = $clog2(VQUAL + 1);
    localparam logic [CW-1:0] VQ_C = CW'(VQUAL);

    typedef struct packed {
        logic          pol;
        logic [CW-1:0] cnt;
    } st_t;

    st_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (v_s != s_q.pol) begin
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_d.cnt == VQ_C) begin
                s_d.pol = v_s;
                s_d.cnt = '0;
            end
        end else begin
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pol = s_q.pol;

    // R2: a change only after the full qualification window
    a_r2_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pol != $past(s_q.pol)) |-> ($past(s_q.cnt) == VQ_C - 1'b1));
endmodule

// File: rtl/lvt_top.sv
module lvt_top
    import lvt_pkg::*;
#(
    parameter int PER_MIN  = 303,
    parameter int PER_MAX  = 454,
    parameter int QUAL     = 4,
    parameter int GAP      = 1362,
    parameter int BMIN     = 80000,
    parameter int BMAX     = 120000,
    parameter int CONT_MIN = 160000,
    parameter int END_GAP  = 40000,
    parameter int VQUAL    = 454
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_v_high,
    input  logic tone_raw,
    input  logic cfg_tone_to_pos,
    input  logic frame_seen,
    input  logic reset_cmd,
    output logic legacy_mode,
    output logic pol_horiz,
    output logic band_high,
    output logic pos_b,
    output logic tone_det
);
    logic [1:0] sync_out;
    logic       pol_f;
    logic       present;
    tone_evt_t  evt;

    lvt_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({bus_v_high, tone_raw}), .q(sync_out)
    );

    lvt_tone_qual #(.PER_MIN(PER_MIN), .PER_MAX(PER_MAX), .QUAL(QUAL), .GAP(GAP)) u_qual (
        .clk(clk), .rst_n(rst_n), .tone_s(sync_out[0]), .present(present)
    );

    lvt_burst_class #(.BMIN(BMIN), .BMAX(BMAX), .CONT_MIN(CONT_MIN), .END_GAP(END_GAP)) u_class (
        .clk(clk), .rst_n(rst_n), .present(present), .evt(evt)
    );

    lvt_volt_filt #(.VQUAL(VQUAL)) u_volt (
        .clk(clk), .rst_n(rst_n), .v_s(sync_out[1]), .pol(pol_f)
    );

    typedef struct packed {
        logic leg;
        logic pol;
        logic band;
        logic pos;
    } out_t;

    out_t o_q, o_d;

    always_comb begin
        o_d = o_q;
        if (reset_cmd)       o_d.leg = 1'b1;
        else if (frame_seen) o_d.leg = 1'b0;
        if (o_q.leg) begin
            o_d.pol = pol_f;
            if (evt.cont_on) begin
                if (cfg_tone_to_pos) o_d.pos  = 1'b1;
                else                 o_d.band = 1'b1;
            end
            if (evt.cont_off) begin
                if (cfg_tone_to_pos) o_d.pos  = 1'b0;
                else                 o_d.band = 1'b0;
            end
            if (evt.pos_a) o_d.pos = 1'b0;
            if (evt.pos_b) o_d.pos = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '{leg: 1'b1, pol: 1'b0, band: 1'b0, pos: 1'b0};
        else        o_q <= o_d;
    end

    assign legacy_mode = o_q.leg;
    assign pol_horiz   = o_q.pol;
    assign band_high   = o_q.band;
    assign pos_b       = o_q.pos;
    assign tone_det    = present;

    // R10: outputs frozen outside legacy mode
    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !o_q.leg |=> $stable({o_q.pol, o_q.band, o_q.pos}));
    // R10: a return request always restores legacy mode
    a_r10_return: assert property (@(posedge clk) disable iff (!rst_n)
        reset_cmd |=> o_q.leg);
    // R5: band line follows continuous tone when routed there
    a_r5_band_on: assert property (@(posedge clk) disable iff (!rst_n)
        (o_q.leg && evt.cont_on && !cfg_tone_to_pos) |=> o_q.band);
endmodule

// File: tb/tb_lvt_top.sv
module tb_lvt_top;
    localparam int P_MIN = 8, P_MAX = 12, P_QUAL = 3, P_GAP = 36;
    localparam int P_BMIN = 150, P_BMAX = 250, P_CONT = 400, P_END = 300, P_VQ = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_v_high = 1'b0, tone_raw = 1'b0, cfg = 1'b0, frame_seen = 1'b0, reset_cmd = 1'b0;
    logic legacy_mode, pol_horiz, band_high, pos_b, tone_det;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    lvt_top #(.PER_MIN(P_MIN), .PER_MAX(P_MAX), .QUAL(P_QUAL), .GAP(P_GAP),
              .BMIN(P_BMIN), .BMAX(P_BMAX), .CONT_MIN(P_CONT), .END_GAP(P_END),
              .VQUAL(P_VQ)) dut (
        .clk(clk), .rst_n(rst_n), .bus_v_high(bus_v_high), .tone_raw(tone_raw),
        .cfg_tone_to_pos(cfg), .frame_seen(frame_seen), .reset_cmd(reset_cmd),
        .legacy_mode(legacy_mode), .pol_horiz(pol_horiz), .band_high(band_high),
        .pos_b(pos_b), .tone_det(tone_det)
    );

    // behavioural reference model
    int  m_hist_t[$], m_hist_v[$];
    int  m_last_rise, m_good, m_now;
    bit  m_pres;
    int  m_seg_start, m_quiet;
    bit  m_cont, m_pend, m_bseen;
    int  m_nshort, m_vrun;
    bit  m_vpol;
    bit  m_leg, m_pol, m_band, m_pos;

    task automatic model_reset();
        m_hist_t = '{0, 0, 0}; m_hist_v = '{0, 0};
        m_last_rise = -100000; m_good = 0; m_now = 0; m_pres = 0;
        m_seg_start = 0; m_quiet = 0; m_cont = 0; m_pend = 0; m_bseen = 0; m_nshort = 0;
        m_vrun = 0; m_vpol = 0;
        m_leg = 1; m_pol = 0; m_band = 0; m_pos = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            bit rise, pres_n, cont_on, cont_off, ev_a, ev_b, vpol_n, leg_n;
            int len;
            // tone history: index 0 newest synchronised sample, 1 previous
            rise = (m_hist_t[1] == 1) && (m_hist_t[2] == 0);
            pres_n = m_pres;
            if (rise) begin
                if (m_now - m_last_rise >= P_MIN && m_now - m_last_rise <= P_MAX) begin
                    m_good = (m_good < P_QUAL) ? m_good + 1 : m_good;
                    if (m_good == P_QUAL) pres_n = 1;
                end else m_good = 0;
                m_last_rise = m_now;
            end else if (m_now - m_last_rise + 1 == P_GAP) begin
                pres_n = 0; m_good = 0;
            end
            // segment classification on the previous presence value
            cont_on = 0; cont_off = 0; ev_a = 0; ev_b = 0;
            if (m_pres) begin
                len = m_now - m_seg_start + 1;
                if (!m_cont && len == P_CONT) begin
                    m_cont = 1; cont_on = 1; m_pend = 0; m_bseen = 0; m_nshort = 0; m_quiet = 0;
                end
            end
            if (!m_pres && m_seg_start >= 0 && m_hist_pp) begin
                len = m_now - m_seg_start;
                if (len > P_CONT) len = P_CONT;
                m_quiet = 0;
                if (m_cont) begin m_cont = 0; cont_off = 1; end
                else if (len >= P_BMIN && len <= P_BMAX) begin m_bseen = 1; m_pend = 1; end
                else if (len < P_BMIN) begin m_nshort = (m_nshort < 3) ? m_nshort + 1 : 3; m_pend = 1; end
                else begin m_bseen = 1; m_nshort = 3; m_pend = 1; end
            end else if (!m_pres && m_pend) begin
                m_quiet++;
                if (m_quiet == P_END) begin
                    if (m_bseen && m_nshort == 0) ev_a = 1;
                    else if (!m_bseen && m_nshort >= 2) ev_b = 1;
                    m_pend = 0; m_bseen = 0; m_nshort = 0; m_quiet = 0;
                end
            end
            if (m_pres && !m_hist_pp) m_seg_start = m_now - 1 + 1;
            m_hist_pp = m_pres;
            // voltage filter
            vpol_n = m_vpol;
            if (m_hist_v[1] != m_vpol) begin
                m_vrun++;
                if (m_vrun == P_VQ) begin vpol_n = m_hist_v[1][0]; m_vrun = 0; end
            end else m_vrun = 0;
            // output stage
            leg_n = reset_cmd ? 1 : (frame_seen ? 0 : m_leg);
            if (m_leg) begin
                m_pol = m_vpol;
                if (cont_on)  begin if (cfg) m_pos = 1; else m_band = 1; end
                if (cont_off) begin if (cfg) m_pos = 0; else m_band = 0; end
                if (ev_a) m_pos = 0;
                if (ev_b) m_pos = 1;
            end
            m_leg = leg_n;
            m_vpol = vpol_n;
            m_pres = pres_n;
            m_hist_t.push_front(int'(tone_raw)); void'(m_hist_t.pop_back());
            m_hist_v.push_front(int'(bus_v_high)); void'(m_hist_v.pop_back());
            m_now++;
        end
    end
    bit m_hist_pp = 0;

    task automatic chk(string req, string what, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, "model legacy_mode", legacy_mode, m_leg);
            chk(cur_req, "model pol_horiz", pol_horiz, m_pol);
            chk(cur_req, "model band_high", band_high, m_band);
            chk(cur_req, "model pos_b", pos_b, m_pos);
            chk(cur_req, "model tone_det", tone_det, m_pres);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tone_run(int per, int n);
        for (int i = 0; i < n; i++) begin
            tone_raw = 1'b1; idle(per / 2);
            tone_raw = 1'b0; idle(per - per / 2);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        cur_req = "R1";
        chk("R1", "legacy_mode", legacy_mode, 1'b1);
        chk("R1", "pol_horiz", pol_horiz, 1'b0);
        chk("R1", "band_high", band_high, 1'b0);
        chk("R1", "pos_b", pos_b, 1'b0);
        chk("R1", "tone_det", tone_det, 1'b0);

        cur_req = "R2";
        bus_v_high = 1'b1; idle(5); bus_v_high = 1'b0; idle(30);
        chk("R2", "pol after short glitch", pol_horiz, 1'b0);
        bus_v_high = 1'b1; idle(30);
        chk("R2", "pol after 18V held", pol_horiz, 1'b1);

        cur_req = "R3";
        tone_run(6, 40);
        chk("R3", "tone_det fast tone", tone_det, 1'b0);
        tone_run(16, 30);
        chk("R3", "tone_det slow tone", tone_det, 1'b0);
        chk("R3", "band after rejected tone", band_high, 1'b0);
        idle(60);

        cur_req = "R5";
        tone_run(10, 50);
        chk("R3", "tone_det valid tone", tone_det, 1'b1);
        chk("R5", "band on continuous tone", band_high, 1'b1);
        chk("R5", "pos untouched", pos_b, 1'b0);
        idle(60);
        chk("R4", "tone_det after silence", tone_det, 1'b0);
        chk("R5", "band off after loss", band_high, 1'b0);

        cur_req = "R6";
        cfg = 1'b1;
        tone_run(10, 50);
        chk("R6", "pos on continuous tone", pos_b, 1'b1);
        chk("R6", "band untouched", band_high, 1'b0);
        idle(60);
        chk("R6", "pos off after loss", pos_b, 1'b0);
        cfg = 1'b0;

        cur_req = "R8";
        for (int k = 0; k < 3; k++) begin
            tone_run(10, 8); idle(100);
        end
        idle(400);
        chk("R8", "pos after modulated burst", pos_b, 1'b1);

        cur_req = "R7";
        tone_run(10, 20); idle(400);
        chk("R7", "pos after plain burst", pos_b, 1'b0);

        cur_req = "R9";
        for (int k = 0; k < 2; k++) begin
            tone_run(10, 8); idle(100);
        end
        idle(400);
        chk("R8", "pos set before odd segment", pos_b, 1'b1);
        tone_run(10, 27); idle(400);
        chk("R9", "pos after odd-length segment", pos_b, 1'b1);
        chk("R9", "band after odd-length segment", band_high, 1'b0);

        cur_req = "R10";
        frame_seen = 1'b1; idle(1); frame_seen = 1'b0; idle(1);
        chk("R10", "legacy cleared", legacy_mode, 1'b0);
        bus_v_high = 1'b0; idle(40);
        chk("R10", "pol frozen", pol_horiz, 1'b1);
        tone_run(10, 50);
        chk("R10", "band frozen", band_high, 1'b0);
        idle(60);
        tone_run(10, 20); idle(400);
        chk("R10", "pos frozen", pos_b, 1'b1);
        reset_cmd = 1'b1; frame_seen = 1'b1; idle(1);
        reset_cmd = 1'b0; frame_seen = 1'b0; idle(1);
        chk("R10", "legacy restored, return wins", legacy_mode, 1'b1);
        idle(3);
        chk("R2", "pol follows after return", pol_horiz, 1'b0);

        idle(5);
        finish_run();
    end
endmodule